// File: doc/BRIEF.md
# NAND Page Program Engine

This block writes one page of a small-page NAND device. A caller gives a page number and a column window (first column inclusive, last column exclusive) and then feeds a byte stream holding only the bytes inside that window. If the caller asks for it, the stream also holds the spare-area bytes, ECC included. Every column outside the window is sent as 0xFF, and the spare area is sent as 0xFF when no spare bytes are supplied. The device therefore always receives a complete page image.

The engine talks to a bus sequencer through a single request/acknowledge port. Each request is one command byte, one address byte, one data write or one data read. Before loading, it reads the device status and refuses to program when the device reports write protection. After the confirm command it waits for the device to finish, within a bounded time, and checks the pass/fail bit. An optional read-back pass then compares every byte the caller supplied against what the device returns. A parameter selects how completion is detected: status polling, or a ready/busy pin.

Top module: `nand_page_prog`

## Requirements
- R1: Each operation begins with command 0x70 and one status read. If status bit 7 reads 0, the operation ends with result 1 (write-protected). No 0x80 command is sent and no stream byte is taken.
- R2: A data-area column below `col_first` or at or above `col_last` is written as 0xFF. Columns inside the window take stream bytes in ascending column order.
- R3: When `oob_en` is 1, the OOB_SIZE spare bytes come from the stream, after the window bytes. When it is 0, all spare bytes are written as 0xFF and no spare byte is taken.
- R4: The bus order for a program is as follows. Command 0x80. Address byte 0x00. The page number, low byte first (two bytes at the default PAGE_BITS=16). PAGE_SIZE data writes, then OOB_SIZE spare writes, then command 0x10. The kind field uses 0 command, 1 address, 2 write, 3 read. A request stays raised with the same kind and data until acknowledged.
- R5: In polling mode (USE_RB=0), completion is found by one 0x70 command followed by status reads, repeated while status bit 6 is 0.
- R6: If the device has not reported ready within TIMEOUT_CYC cycles of the 0x10 acknowledge, the operation ends with result 3 (timeout).
- R7: If the final status read shows bit 0 set, the operation ends with result 2 (program failed), and no read-back follows.
- R8: With `verify_en` set, the read-back sends a pointer command and then the address bytes. The pointer command is 0x00 for a first column below 256, 0x01 for 256 up to PAGE_SIZE-1, and 0x50 for PAGE_SIZE. The address bytes are the low 8 bits of the first column, then the page bytes. After READ_WAIT cycles the engine reads from the first column. It compares the window bytes, and the spare bytes when they were supplied. The first mismatch ends with result 4, without further reads. An empty window with no spare bytes skips the read-back.
- R9: `busy` is high from the cycle after an accepted `start` through the `done` cycle. `done` is a one-cycle pulse carrying `result`. Result 0 means success.
- R10: With `verify_en` clear, no bus activity follows the final status read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (accepted when idle) |
| page_addr | input | PAGE_BITS | Page number |
| col_first | input | clog2(PAGE_SIZE+1) | First column of the window |
| col_last | input | clog2(PAGE_SIZE+1) | Column after the last one of the window |
| oob_en | input | 1 | Spare bytes are supplied in the stream |
| verify_en | input | 1 | Run the read-back compare |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 3 | 0 ok, 1 protected, 2 failed, 3 timeout, 4 mismatch |
| in_valid | input | 1 | Stream byte available |
| in_byte | input | 8 | Stream byte |
| in_ready | output | 1 | Engine takes the stream byte this cycle |
| bus_req | output | 1 | Bus request |
| bus_kind | output | 2 | 0 command, 1 address, 2 write, 3 read |
| bus_wdata | output | 8 | Command, address or write byte |
| bus_ack | input | 1 | Request done; read data valid |
| bus_rdata | input | 8 | Byte returned by a read |
| rb_ready | input | 1 | Ready/busy pin, high when ready (tie high if absent) |

## Verification
A full window with spare bytes and read-back shows that no padding is applied when none is due, and that every one of the 528 positions is compared. Windows that start inside the first half, start in the second half, or are empty tell apart the lead and tail padding, the two read pointer commands and the skipped read-back. Separate runs flip the protect bit, set the fail bit, stall the device past the timeout and corrupt one stored byte, so each error code is reached by its own cause. The verify-off run confirms the bus goes quiet after the final status.

// File: rtl/npe_pkg.sv
package npe_pkg;
   typedef enum logic [1:0] {BK_CMD = 2'd0, BK_ADDR = 2'd1, BK_WR = 2'd2, BK_RD = 2'd3} bus_kind_t;
   typedef enum logic [2:0] {
      RES_OK = 3'd0, RES_WP = 3'd1, RES_FAIL = 3'd2, RES_TIMEOUT = 3'd3, RES_VERIFY = 3'd4
   } result_t;
   localparam logic [7:0] OP_STATUS  = 8'h70;
   localparam logic [7:0] OP_SEQIN   = 8'h80;
   localparam logic [7:0] OP_CONFIRM = 8'h10;
   localparam logic [7:0] OP_READA   = 8'h00;
   localparam logic [7:0] OP_READB   = 8'h01;
   localparam logic [7:0] OP_SPARE   = 8'h50;
   localparam logic [7:0] PAD_BYTE   = 8'hFF;
endpackage

// File: rtl/npe_colsel.sv
module npe_colsel #(
   parameter int PAGE_SIZE = 512,
   parameter int IW = 10,
   parameter int CW = 10
) (
   input  logic [IW-1:0] idx,
   input  logic [CW-1:0] first,
   input  logic [CW-1:0] last,
   input  logic          spare_en,
   output logic          take
);
   always_comb begin
      if (int'(idx) < PAGE_SIZE)
         take = (int'(idx) >= int'(first)) && (int'(idx) < int'(last));
      else
         take = spare_en;
   end
endmodule

// File: rtl/npe_timer.sv
module npe_timer #(
   parameter int TW = 21
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic [TW-1:0] limit,
   output logic          expired
);
   logic [TW-1:0] cnt;
   assign expired = (cnt >= limit);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt <= '0;
      else if (clr)      cnt <= '0;
      else if (!expired) cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/npe_store.sv
module npe_store #(
   parameter int DEPTH = 528,
   parameter int AW = 10
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [7:0]    wdata,
   input  logic [AW-1:0] raddr,
   output logic [7:0]    rdata
);
   logic [7:0] mem [DEPTH];
   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end
   assign rdata = mem[raddr];
endmodule

// File: rtl/nand_page_prog.sv
module nand_page_prog
   import npe_pkg::*;
#(
   parameter int PAGE_SIZE   = 512,
   parameter int OOB_SIZE    = 16,
   parameter int PAGE_BITS   = 16,
   parameter int TIMEOUT_CYC = 2_000_000,
   parameter int READ_WAIT   = 2500,
   parameter bit USE_RB      = 1'b0
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             start,
   input  logic [PAGE_BITS-1:0]             page_addr,
   input  logic [$clog2(PAGE_SIZE+1)-1:0]   col_first,
   input  logic [$clog2(PAGE_SIZE+1)-1:0]   col_last,
   input  logic                             oob_en,
   input  logic                             verify_en,
   output logic                             busy,
   output logic                             done,
   output logic [2:0]                       result,
   input  logic                             in_valid,
   input  logic [7:0]                       in_byte,
   output logic                             in_ready,
   output logic                             bus_req,
   output logic [1:0]                       bus_kind,
   output logic [7:0]                       bus_wdata,
   input  logic                             bus_ack,
   input  logic [7:0]                       bus_rdata,
   input  logic                             rb_ready
);
   localparam int TOTAL = PAGE_SIZE + OOB_SIZE;
   localparam int IW    = $clog2(TOTAL);
   localparam int CW    = $clog2(PAGE_SIZE + 1);
   localparam int NPB   = (PAGE_BITS + 7) / 8;
   localparam int NADDR = 1 + NPB;
   localparam int AB    = 8 * NPB;
   localparam int TMAX  = (TIMEOUT_CYC > READ_WAIT) ? TIMEOUT_CYC : READ_WAIT;
   localparam int TW    = $clog2(TMAX + 1);

   // elaboration-time parameter checks
   if (PAGE_SIZE != 256 && PAGE_SIZE != 512) begin : g_bad_page
      $error("PAGE_SIZE must be 256 or 512");
   end
   if (OOB_SIZE != PAGE_SIZE / 32) begin : g_bad_oob
      $error("OOB_SIZE must be PAGE_SIZE/32");
   end
   if (PAGE_BITS < 8 || PAGE_BITS > 24) begin : g_bad_pbits
      $error("PAGE_BITS must lie in 8..24");
   end
   if (TIMEOUT_CYC < 1 || READ_WAIT < 1) begin : g_bad_wait
      $error("wait limits must be positive");
   end

   typedef enum logic [3:0] {
      S_IDLE, S_WPCMD, S_WPRD, S_SEQ, S_ADDR, S_DATA, S_CONF, S_RBWAIT,
      S_STCMD, S_STRD, S_VPTR, S_VWAIT, S_VREAD, S_DONE
   } st_t;

   st_t            st;
   logic [IW-1:0]  idx;
   logic [2:0]     acnt;
   logic           hold;
   logic [7:0]     wbyte;
   result_t        res_q;
   logic           vph;
   logic [AB-1:0]  pg_q;
   logic [CW-1:0]  cs_q, ce_q;
   logic           oob_q, ver_q;

   logic           take, tmr_exp, tmr_clr, last_addr, last_rd, skip_verify;
   logic [TW-1:0]  tmr_lim;
   logic [7:0]     addr_byte, ptr_cmd, buf_q;
   logic [AB-1:0]  pg_sh;
   logic [2:0]     aidx;
   logic           wait_go, wait_to, ready_ok;
   st_t            after_conf;

   // completion detection variant
   if (USE_RB) begin : g_rb
      assign after_conf = S_RBWAIT;
      assign wait_go    = rb_ready;
      assign wait_to    = tmr_exp;
      assign ready_ok   = 1'b1;
   end else begin : g_poll
      assign after_conf = S_STCMD;
      assign wait_go    = tmr_exp && rb_ready;
      assign wait_to    = 1'b0;
      assign ready_ok   = bus_rdata[6];
   end

   npe_colsel #(.PAGE_SIZE(PAGE_SIZE), .IW(IW), .CW(CW)) i_colsel (
      .idx(idx), .first(cs_q), .last(ce_q), .spare_en(oob_q), .take(take)
   );

   npe_store #(.DEPTH(TOTAL), .AW(IW)) i_store (
      .clk(clk), .we((st == S_DATA) && in_ready && in_valid), .waddr(idx),
      .wdata(in_byte), .raddr(idx), .rdata(buf_q)
   );

   assign tmr_lim = (st == S_VWAIT && !USE_RB) ? TW'(READ_WAIT) : TW'(TIMEOUT_CYC);
   assign tmr_clr = bus_ack && ((st == S_CONF) || (st == S_ADDR && vph && last_addr));

   npe_timer #(.TW(TW)) i_timer (
      .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .limit(tmr_lim), .expired(tmr_exp)
   );

   assign aidx        = acnt - 3'd1;
   assign pg_sh       = pg_q >> (8 * aidx);
   assign addr_byte   = (acnt == 3'd0) ? (vph ? cs_q[7:0] : 8'h00) : pg_sh[7:0];
   assign last_addr   = (int'(acnt) == NADDR - 1);
   assign ptr_cmd     = (int'(cs_q) >= PAGE_SIZE) ? OP_SPARE :
                        ((int'(cs_q) >= 256) ? OP_READB : OP_READA);
   assign last_rd     = (!oob_q && (int'(idx) == int'(ce_q) - 1)) || (int'(idx) == TOTAL - 1);
   assign skip_verify = !ver_q || ((cs_q == ce_q) && !oob_q);

   assign busy   = (st != S_IDLE);
   assign done   = (st == S_DONE);
   assign result = res_q;

   always_comb begin
      bus_req   = 1'b0;
      bus_kind  = BK_CMD;
      bus_wdata = 8'h00;
      in_ready  = 1'b0;
      unique case (st)
         S_WPCMD, S_STCMD: begin bus_req = 1'b1; bus_wdata = OP_STATUS; end
         S_WPRD, S_STRD, S_VREAD: begin bus_req = 1'b1; bus_kind = BK_RD; end
         S_SEQ:  begin bus_req = 1'b1; bus_wdata = OP_SEQIN; end
         S_ADDR: begin bus_req = 1'b1; bus_kind = BK_ADDR; bus_wdata = addr_byte; end
         S_DATA: begin
            bus_kind  = BK_WR;
            bus_wdata = hold ? wbyte : PAD_BYTE;
            bus_req   = hold || !take;
            in_ready  = take && !hold;
         end
         S_CONF: begin bus_req = 1'b1; bus_wdata = OP_CONFIRM; end
         S_VPTR: begin bus_req = 1'b1; bus_wdata = ptr_cmd; end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= S_IDLE;
         idx   <= '0;
         acnt  <= '0;
         hold  <= 1'b0;
         wbyte <= 8'h00;
         res_q <= RES_OK;
         vph   <= 1'b0;
         pg_q  <= '0;
         cs_q  <= '0;
         ce_q  <= '0;
         oob_q <= 1'b0;
         ver_q <= 1'b0;
      end else begin
         unique case (st)
            S_IDLE: if (start) begin
               pg_q  <= AB'(page_addr);
               cs_q  <= col_first;
               ce_q  <= col_last;
               oob_q <= oob_en;
               ver_q <= verify_en;
               res_q <= RES_OK;
               st    <= S_WPCMD;
            end
            S_WPCMD: if (bus_ack) st <= S_WPRD;
            S_WPRD: if (bus_ack) begin
               if (!bus_rdata[7]) begin res_q <= RES_WP; st <= S_DONE; end
               else st <= S_SEQ;
            end
            S_SEQ: if (bus_ack) begin acnt <= '0; vph <= 1'b0; st <= S_ADDR; end
            S_ADDR: if (bus_ack) begin
               if (last_addr) begin
                  idx  <= '0;
                  hold <= 1'b0;
                  st   <= vph ? S_VWAIT : S_DATA;
               end else acnt <= acnt + 3'd1;
            end
            S_DATA: begin
               if (in_ready && in_valid) begin
                  hold  <= 1'b1;
                  wbyte <= in_byte;
               end
               if (bus_req && bus_ack) begin
                  hold <= 1'b0;
                  if (int'(idx) == TOTAL - 1) st <= S_CONF;
                  else idx <= idx + 1'b1;
               end
            end
            S_CONF: if (bus_ack) st <= after_conf;
            S_RBWAIT: begin
               if (rb_ready) st <= S_STCMD;
               else if (tmr_exp) begin res_q <= RES_TIMEOUT; st <= S_DONE; end
            end
            S_STCMD: if (bus_ack) st <= S_STRD;
            S_STRD: if (bus_ack) begin
               if (!ready_ok) begin
                  if (tmr_exp) begin res_q <= RES_TIMEOUT; st <= S_DONE; end
               end else if (bus_rdata[0]) begin
                  res_q <= RES_FAIL; st <= S_DONE;
               end else if (skip_verify) st <= S_DONE;
               else st <= S_VPTR;
            end
            S_VPTR: if (bus_ack) begin acnt <= '0; vph <= 1'b1; st <= S_ADDR; end
            S_VWAIT: begin
               if (wait_go) begin idx <= IW'(cs_q); st <= S_VREAD; end
               else if (wait_to) begin res_q <= RES_TIMEOUT; st <= S_DONE; end
            end
            S_VREAD: if (bus_ack) begin
               if (take && (bus_rdata != buf_q)) begin res_q <= RES_VERIFY; st <= S_DONE; end
               else if (last_rd) st <= S_DONE;
               else idx <= idx + 1'b1;
            end
            S_DONE: st <= S_IDLE;
            default: st <= S_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/npe_check.sv
module npe_check #(
   parameter int TOTAL = 528
) (
   input logic       clk,
   input logic       rst_n,
   input logic       start,
   input logic       busy,
   input logic       done,
   input logic [2:0] result,
   input logic       in_ready,
   input logic       bus_req,
   input logic [1:0] bus_kind,
   input logic [7:0] bus_wdata,
   input logic       bus_ack,
   input logic [7:0] bus_rdata
);
   logic       seq_seen;
   int         wr_cnt;
   logic [7:0] last_rd;
   logic       xfer;
   assign xfer = bus_req && bus_ack;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seq_seen <= 1'b0;
         wr_cnt   <= 0;
         last_rd  <= 8'h00;
      end else begin
         if (start && !busy) seq_seen <= 1'b0;
         else if (xfer && bus_kind == 2'd0 && bus_wdata == 8'h80) seq_seen <= 1'b1;
         if (xfer && bus_kind == 2'd0 && bus_wdata == 8'h80) wr_cnt <= 0;
         else if (xfer && bus_kind == 2'd2) wr_cnt <= wr_cnt + 1;
         if (xfer && bus_kind == 2'd3) last_rd <= bus_rdata;
      end
   end

   p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && !bus_ack |=> bus_req && $stable(bus_kind) && $stable(bus_wdata));
   p_all_bytes_r4: assert property (@(posedge clk) disable iff (!rst_n)
      xfer && bus_kind == 2'd0 && bus_wdata == 8'h10 |-> wr_cnt == TOTAL);
   p_wp_no_seq_r1: assert property (@(posedge clk) disable iff (!rst_n)
      done && result == 3'd1 |-> !seq_seen && !last_rd[7]);
   p_fail_bit0_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done && result == 3'd2 |-> last_rd[0]);
   p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_stream_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> busy && !done && !bus_req);
endmodule

bind nand_page_prog npe_check #(.TOTAL(PAGE_SIZE + OOB_SIZE)) i_npe_check (
   .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .result(result),
   .in_ready(in_ready), .bus_req(bus_req), .bus_kind(bus_kind), .bus_wdata(bus_wdata),
   .bus_ack(bus_ack), .bus_rdata(bus_rdata)
);

// File: tb/test_nand_page_prog.sv
module test_nand_page_prog;
   import npe_pkg::*;
   localparam int PS = 512, OS = 16, TOT = PS + OS, PB = 16, TO = 400, RW = 4;

   logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, oob_en = 1'b0, verify_en = 1'b0;
   logic [PB-1:0] page_addr = '0;
   logic [9:0] col_first = '0, col_last = '0;
   logic busy, done, in_ready, bus_req, in_valid;
   logic [2:0] result;
   logic [7:0] in_byte, bus_wdata, bus_rdata;
   logic [1:0] bus_kind;
   logic bus_ack, rb_ready;

   always #5 clk = ~clk;

   nand_page_prog #(.PAGE_SIZE(PS), .OOB_SIZE(OS), .PAGE_BITS(PB), .TIMEOUT_CYC(TO),
                    .READ_WAIT(RW), .USE_RB(1'b0)) i_nand_page_prog (
      .clk(clk), .rst_n(rst_n), .start(start), .page_addr(page_addr), .col_first(col_first),
      .col_last(col_last), .oob_en(oob_en), .verify_en(verify_en), .busy(busy), .done(done),
      .result(result), .in_valid(in_valid), .in_byte(in_byte), .in_ready(in_ready),
      .bus_req(bus_req), .bus_kind(bus_kind), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
      .bus_rdata(bus_rdata), .rb_ready(rb_ready));

   int checks = 0, fails = 0;
   bit finished = 0;
   task automatic chk(bit ok, string tag, int act, int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // ---------------- device model and scoreboard monitor ----------------
   logic [9:0] exp_q[$];
   logic [7:0] flash[TOT], pbuf[TOT], exp_img[TOT];
   int busy_cnt = 0, prog_time = 20, wr_ptr = 0, rd_ptr = 0, rd_base = 0, mode = 0;
   int data_reads = 0, corrupt_idx = -1, addr_n = 0;
   bit wp = 0, fail_flag = 0;

   assign rb_ready = 1'b1;

   initial begin
      bus_ack = 1'b0; bus_rdata = 8'h00;
      for (int i = 0; i < TOT; i++) flash[i] = 8'h00;
      forever begin
         @(negedge clk);
         if (busy_cnt > 0) busy_cnt--;
         if (bus_ack) bus_ack = 1'b0;
         else if (bus_req && rst_n) begin
            if (bus_kind == 2'd3) begin
               if (mode == 0) bus_rdata = {~wp, (busy_cnt == 0), 5'b0, fail_flag};
               else begin
                  bus_rdata = flash[rd_ptr] ^ ((rd_ptr == corrupt_idx) ? 8'h01 : 8'h00);
                  rd_ptr++;
                  data_reads++;
               end
            end else begin
               if (exp_q.size() == 0) chk(0, "R4 unexpected bus op", {bus_kind, bus_wdata}, 0);
               else begin
                  logic [9:0] e;
                  e = exp_q.pop_front();
                  chk(e == {bus_kind, bus_wdata}, "R4 bus op order", {bus_kind, bus_wdata}, e);
               end
               if (bus_kind == 2'd0) begin
                  case (bus_wdata)
                     8'h70: mode = 0;
                     8'h80: begin mode = 1; wr_ptr = 0; end
                     8'h10: begin
                        for (int i = 0; i < TOT; i++) flash[i] = pbuf[i];
                        busy_cnt = prog_time;
                     end
                     8'h00: begin mode = 2; rd_base = 0; addr_n = 0; end
                     8'h01: begin mode = 2; rd_base = 256; addr_n = 0; end
                     8'h50: begin mode = 2; rd_base = PS; addr_n = 0; end
                     default: ;
                  endcase
               end else if (bus_kind == 2'd1) begin
                  if (mode == 2 && addr_n == 0) rd_ptr = rd_base + int'(bus_wdata);
                  addr_n++;
               end else if (bus_kind == 2'd2 && wr_ptr < TOT) begin
                  pbuf[wr_ptr] = bus_wdata;
                  wr_ptr++;
               end
            end
            bus_ack = 1'b1;
         end
      end
   end

   // ---------------- byte stream source ----------------
   logic [7:0] src[$];
   int sptr = 0;
   bit pend = 0;
   assign in_valid = (sptr < src.size());
   assign in_byte  = in_valid ? src[sptr] : 8'h00;
   initial forever begin
      @(negedge clk);
      if (pend) sptr++;
      #1 pend = in_ready && in_valid;
   end

   int done_cnt = 0;
   logic [2:0] last_res = 3'd0;
   initial forever begin
      @(negedge clk);
      if (done) begin done_cnt++; last_res = result; end
   end

   function automatic logic [7:0] val(int seed, int k);
      return 8'(seed * 31 + k * 13 + (k >> 3));
   endfunction

   // driver: builds the expected bus stream and page image, runs one operation
   task automatic run_op(int pg, int cs, int ce, bit oob, bit ver, int seed,
                         logic [2:0] exp_res, string tag);
      int k = 0, d0, n;
      src.delete(); exp_q.delete();
      sptr = 0; pend = 0; data_reads = 0;
      for (int c = 0; c < PS; c++)
         if (c >= cs && c < ce) begin exp_img[c] = val(seed, k); src.push_back(exp_img[c]); k++; end
         else exp_img[c] = 8'hFF;
      for (int c = PS; c < TOT; c++)
         if (oob) begin exp_img[c] = val(seed, k); src.push_back(exp_img[c]); k++; end
         else exp_img[c] = 8'hFF;
      exp_q.push_back({BK_CMD, OP_STATUS});
      if (exp_res != RES_WP) begin
         exp_q.push_back({BK_CMD, OP_SEQIN});
         exp_q.push_back({BK_ADDR, 8'h00});
         exp_q.push_back({BK_ADDR, 8'(pg)});
         exp_q.push_back({BK_ADDR, 8'(pg >> 8)});
         for (int c = 0; c < TOT; c++) exp_q.push_back({BK_WR, exp_img[c]});
         exp_q.push_back({BK_CMD, OP_CONFIRM});
         exp_q.push_back({BK_CMD, OP_STATUS});
         if ((exp_res == RES_OK || exp_res == RES_VERIFY) && ver && !(cs == ce && !oob)) begin
            exp_q.push_back({BK_CMD, (cs >= PS) ? OP_SPARE : ((cs >= 256) ? OP_READB : OP_READA)});
            exp_q.push_back({BK_ADDR, 8'(cs)});
            exp_q.push_back({BK_ADDR, 8'(pg)});
            exp_q.push_back({BK_ADDR, 8'(pg >> 8)});
         end
      end
      d0 = done_cnt;
      n  = src.size();
      @(negedge clk);
      page_addr = PB'(pg); col_first = 10'(cs); col_last = 10'(ce);
      oob_en = oob; verify_en = ver; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b1, {tag, " R9 busy after start"}, busy, 1);
      for (int t = 0; t < 20000 && done_cnt == d0; t++) @(negedge clk);
      repeat (3) @(negedge clk);
      chk(done_cnt == d0 + 1, {tag, " R9 one done pulse"}, done_cnt - d0, 1);
      chk(last_res == exp_res, {tag, " result code"}, last_res, exp_res);
      chk(busy == 1'b0, {tag, " R9 idle after done"}, busy, 0);
      chk(exp_q.size() == 0, {tag, " R4 all expected ops seen"}, exp_q.size(), 0);
      chk(sptr == ((exp_res == RES_WP) ? 0 : n), {tag, " R2 R3 stream bytes taken"},
          sptr, (exp_res == RES_WP) ? 0 : n);
   endtask

   task automatic chk_image(string tag);
      int bad = 0;
      for (int i = 0; i < TOT; i++) if (flash[i] != exp_img[i]) bad++;
      chk(bad == 0, tag, bad, 0);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++; fails++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      repeat (5) @(negedge clk);
      chk(busy == 0 && done == 0 && bus_req == 0 && in_ready == 0, "R9 reset state",
          {busy, done, bus_req, in_ready}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R1: write-protected device
      wp = 1;
      run_op(16'h1234, 0, 512, 1, 1, 1, RES_WP, "R1 protect");
      wp = 0;

      // R2 R3 R4 R5 R8: full page with spare and read-back
      run_op(16'hA55A, 0, 512, 1, 1, 2, RES_OK, "R4 full page");
      chk_image("R3 full page image");
      chk(data_reads == TOT, "R8 full read-back count", data_reads, TOT);

      // R2: window in first half, spare absent
      run_op(16'h0102, 100, 300, 0, 1, 3, RES_OK, "R2 window low");
      chk_image("R2 padded image");
      chk(data_reads == 200, "R8 window read count", data_reads, 200);

      // R8: window starting in second half, 0x01 pointer
      run_op(16'h00FF, 300, 400, 1, 1, 4, RES_OK, "R8 second half");
      chk_image("R3 spare after window");
      chk(data_reads == TOT - 300, "R8 second half read count", data_reads, TOT - 300);

      // R7: program failure bit
      fail_flag = 1;
      run_op(16'h0033, 10, 20, 0, 1, 5, RES_FAIL, "R7 status fail");
      chk(data_reads == 0, "R7 no read-back after fail", data_reads, 0);
      fail_flag = 0;

      // R6: device never ready
      prog_time = 100000;
      run_op(16'h0044, 0, 8, 0, 1, 6, RES_TIMEOUT, "R6 timeout");
      busy_cnt = 0; prog_time = 20;

      // R8: corrupted byte detected, reads stop at it
      corrupt_idx = 150;
      run_op(16'h0055, 100, 300, 0, 1, 7, RES_VERIFY, "R8 mismatch");
      chk(data_reads == 51, "R8 stop at first mismatch", data_reads, 51);
      corrupt_idx = -1;

      // R10: no verify
      run_op(16'h0066, 5, 500, 1, 0, 8, RES_OK, "R10 no verify");
      chk(data_reads == 0, "R10 no data reads", data_reads, 0);
      chk_image("R2 image no verify");

      // R8: empty window and no spare skips read-back
      run_op(16'h0077, 50, 50, 0, 1, 9, RES_OK, "R8 empty window");
      chk(data_reads == 0, "R8 empty window no reads", data_reads, 0);
      chk_image("R3 all pad image");

      if (!finished) begin
         finished = 1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule